// File: doc/BRIEF.md
# Parallel NOR Flash Sector Erase Sequencer

This block erases a contiguous range of sectors in a parallel NOR flash bank. A start pulse hands it a first and a last sector index, a command family and, through inputs held steady for the whole run, a per-sector protect bitmap, a table of sector start addresses and the bank base address. The block first checks the range. It then counts the protected sectors in that range and walks the range in order. Protected sectors are skipped. Every other sector gets the erase command string of the selected family. After that the block waits a fixed minimum time and polls the status word at the sector address until bit 7 is set in every device lane.

Two families are supported. In the status-register family, commands go straight to the sector address, and a stuck erase is suspended before the device returns to read mode. In the unlock-sequence family, a handshake is written to fixed offsets above the bank base before the sector command. Each sector ends with a read-mode write to the bank base. The first timeout ends the whole run as a failure. While the block waits, a progress tick pulses at a fixed interval. A one-cycle done pulse marks the end of a run, and the pass flag and protected-sector count are valid from that cycle on.

Top module: `fes_erase_seq`

## Requirements
- R1: A start whose first index is negative, exceeds the last index, or whose last index is past the final sector is refused. Done pulses in the first cycle after the start is taken, with pass low and a protected count of 0, and no bus cycle is issued.
- R2: The protected count equals the number of protect bits set from first to last inclusive. Protected sectors receive no bus cycle of any kind. A range that holds only protected sectors completes with pass high in (sector count + 2) cycles.
- R3: Family 0 (status-register) erases a sector with three consecutive writes to its start address: 0x50, 0x20, 0xD0. Each command byte sits in the low 8 bits of every 16-bit lane of the 32-bit data word, and the upper byte of each lane is zero.
- R4: Family 1 (unlock-sequence) erases a sector with six consecutive writes: 0xAA to base+0x555, 0x55 to base+0x2AA, 0x80 to base+0x555, 0xAA to base+0x555, 0x55 to base+0x2AA, then 0x30 to the sector start address.
- R5: The first status read of a sector takes place exactly MIN_WAIT_CYC+1 cycles after its final erase write.
- R6: A sector counts as erased only when status bit 7 is set in every lane, which means data bits 7 and 23. A word with only some lanes ready keeps the block polling.
- R7: A wait counter starts with the first cycle after the erase command and advances on every waiting cycle. Polling alternates a read cycle and a check cycle. The first check cycle whose count is at or above TIMEOUT_CYC without all lanes ready is a timeout. On a timeout, family 0 writes 0xB0 to the sector address and then the read-mode word. Family 1 writes only its read-mode word. Pass goes low and no later sector is touched.
- R8: Every sector the block erases, whether it succeeds or not, is followed by a read-mode write to the bank base: 0xFF in family 0 and 0xF0 in family 1.
- R9: Tick pulses for one cycle on every TICK_CYC-th waiting cycle of a sector, counted from that sector's erase command. It never pulses outside the wait and poll phases.
- R10: Done is a single-cycle pulse. Pass is high only when every unprotected sector in the range was erased. A start pulse that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| family | input | 1 | 0 = status-register commands, 1 = unlock-sequence commands |
| first_idx | input | IW (5) | Signed first sector index |
| last_idx | input | IW (5) | Signed last sector index |
| protect_map | input | NSECT (8) | One bit per sector, 1 = protected |
| sect_addr_flat | input | NSECT*AW (160) | Sector start addresses, sector i in bits [i*AW +: AW] |
| bank_base | input | AW (20) | Word address of the bank base |
| fl_we | output | 1 | Flash write cycle strobe |
| fl_re | output | 1 | Flash read cycle strobe |
| fl_addr | output | AW (20) | Flash word address |
| fl_wdata | output | DW (32) | Flash write data |
| fl_rdata | input | DW (32) | Flash read data, valid in the cycle after fl_re |
| busy | output | 1 | A run is in progress |
| tick | output | 1 | Progress pulse while waiting |
| done | output | 1 | End-of-run pulse |
| pass | output | 1 | Result of the last run |
| prot_cnt | output | XW+1 (4) | Protected sectors in the last range |

## Verification
A refused range is visible one cycle after the accepting edge. A range of N protected sectors finishes N+2 cycles after the start, and the bench counts cycles from the start pulse to done and compares the count with these exact figures. Read data is expected one cycle after each read strobe. The bench's flash model therefore answers on the falling edge of the read cycle. On every falling edge it logs bus writes, reads and ticks, so each check compares an exact cycle position (the gap of MIN_WAIT_CYC+1 from the final erase write to the first read) or an exact count derived from the waiting length. The bench computes timeout counts on its own by walking the odd check-cycle counts up to TIMEOUT_CYC.

// File: rtl/fes_pkg.sv
package fes_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_CMD, ST_WAIT, ST_PRD, ST_PCHK, ST_SUSP, ST_RDM, ST_FIN
  } fes_state_t;

  typedef enum logic {
    FAM_STATUS = 1'b0,
    FAM_UNLOCK = 1'b1
  } fes_family_t;

  typedef enum logic [1:0] {
    OP_ERASE, OP_SUSPEND, OP_READMODE
  } fes_op_t;

  localparam logic [7:0] C_CLR_STAT   = 8'h50;
  localparam logic [7:0] C_ER_SETUP   = 8'h20;
  localparam logic [7:0] C_ER_CONFIRM = 8'hD0;
  localparam logic [7:0] C_KEY_A      = 8'hAA;
  localparam logic [7:0] C_KEY_B      = 8'h55;
  localparam logic [7:0] C_ER_ARM     = 8'h80;
  localparam logic [7:0] C_ER_SECTOR  = 8'h30;
  localparam logic [7:0] C_SUSPEND    = 8'hB0;
  localparam logic [7:0] C_RD_STATUS  = 8'hFF;
  localparam logic [7:0] C_RD_UNLOCK  = 8'hF0;

  localparam int unsigned KEY_OFS_A = 32'h555;
  localparam int unsigned KEY_OFS_B = 32'h2AA;

endpackage

// File: rtl/fes_prot_count.sv
module fes_prot_count #(
  parameter int NSECT = 8,
  localparam int XW = $clog2(NSECT)
) (
  input  logic [NSECT-1:0] protect_map,
  input  logic [XW-1:0]    first,
  input  logic [XW-1:0]    last,
  output logic [XW:0]      count
);
  logic [NSECT-1:0] hit;

  for (genvar i = 0; i < NSECT; i++) begin : g_win
    assign hit[i] = protect_map[i] && (XW'(i) >= first) && (XW'(i) <= last);
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NSECT; i++) count = count + (XW+1)'(hit[i]);
  end
endmodule

// File: rtl/fes_cmd_gen.sv
module fes_cmd_gen
  import fes_pkg::*;
#(
  parameter int AW = 20,
  parameter int LANES = 2,
  parameter int LANE_W = 16,
  localparam int DW = LANES * LANE_W
) (
  input  fes_family_t   fam,
  input  fes_op_t       op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] saddr,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic          last_step
);
  function automatic logic [DW-1:0] bcast(input logic [7:0] b);
    logic [DW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*LANE_W +: LANE_W] = LANE_W'(b);
    return r;
  endfunction

  localparam logic [AW-1:0] OFS_A = AW'(KEY_OFS_A);
  localparam logic [AW-1:0] OFS_B = AW'(KEY_OFS_B);

  logic [7:0] byte_c;

  always_comb begin
    addr      = saddr;
    byte_c    = C_RD_STATUS;
    last_step = 1'b0;
    unique case (op)
      OP_SUSPEND: byte_c = C_SUSPEND;
      OP_READMODE: begin
        addr   = base;
        byte_c = (fam == FAM_STATUS) ? C_RD_STATUS : C_RD_UNLOCK;
      end
      default: begin
        if (fam == FAM_STATUS) begin
          case (step)
            3'd0:    byte_c = C_CLR_STAT;
            3'd1:    byte_c = C_ER_SETUP;
            default: begin byte_c = C_ER_CONFIRM; last_step = 1'b1; end
          endcase
        end else begin
          case (step)
            3'd0:    begin addr = base + OFS_A; byte_c = C_KEY_A;  end
            3'd1:    begin addr = base + OFS_B; byte_c = C_KEY_B;  end
            3'd2:    begin addr = base + OFS_A; byte_c = C_ER_ARM; end
            3'd3:    begin addr = base + OFS_A; byte_c = C_KEY_A;  end
            3'd4:    begin addr = base + OFS_B; byte_c = C_KEY_B;  end
            default: begin byte_c = C_ER_SECTOR; last_step = 1'b1; end
          endcase
        end
      end
    endcase
    data = bcast(byte_c);
  end
endmodule

// File: rtl/fes_wait_timer.sv
module fes_wait_timer #(
  parameter int MIN_WAIT_CYC = 250_000,
  parameter int TIMEOUT_CYC  = 50_000_000,
  parameter int TICK_CYC     = 250_000_000,
  localparam int TW = $clog2(TIMEOUT_CYC + 2),
  localparam int KW = $clog2(TICK_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic min_done,
  output logic expired,
  output logic tick
);
  localparam logic [TW-1:0] CNT_SAT = TW'(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] CNT_MIN = TW'(MIN_WAIT_CYC - 1);
  localparam logic [TW-1:0] CNT_TMO = TW'(TIMEOUT_CYC);
  localparam logic [KW-1:0] TK_LAST = KW'(TICK_CYC - 1);

  logic [TW-1:0] cnt;
  logic [KW-1:0] tk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tk  <= '0;
    end else if (clr) begin
      cnt <= '0;
      tk  <= '0;
    end else if (run) begin
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      tk <= (tk == TK_LAST) ? '0 : tk + 1'b1;
    end
  end

  assign min_done = run && (cnt == CNT_MIN);
  assign expired  = cnt >= CNT_TMO;
  assign tick     = run && (tk == TK_LAST);
endmodule

// File: rtl/fes_erase_seq.sv
module fes_erase_seq
  import fes_pkg::*;
#(
  parameter int NSECT = 8,
  parameter int AW = 20,
  parameter int LANES = 2,
  parameter int LANE_W = 16,
  parameter int MIN_WAIT_CYC = 250_000,
  parameter int TIMEOUT_CYC = 50_000_000,
  parameter int TICK_CYC = 250_000_000,
  localparam int XW = $clog2(NSECT),
  localparam int IW = XW + 2,
  localparam int DW = LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 family,
  input  logic signed [IW-1:0] first_idx,
  input  logic signed [IW-1:0] last_idx,
  input  logic [NSECT-1:0]     protect_map,
  input  logic [NSECT*AW-1:0]  sect_addr_flat,
  input  logic [AW-1:0]        bank_base,
  output logic                 fl_we,
  output logic                 fl_re,
  output logic [AW-1:0]        fl_addr,
  output logic [DW-1:0]        fl_wdata,
  input  logic [DW-1:0]        fl_rdata,
  output logic                 busy,
  output logic                 tick,
  output logic                 done,
  output logic                 pass,
  output logic [XW:0]          prot_cnt
);
  localparam logic signed [IW-1:0] TOP_IDX = IW'(NSECT - 1);

  function automatic logic range_bad(input logic signed [IW-1:0] f,
                                     input logic signed [IW-1:0] l);
    return f[IW-1] || (f > l) || (l > TOP_IDX);
  endfunction

  function automatic logic lanes_ready(input logic [DW-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int l = 0; l < LANES; l++) ok = ok & d[l*LANE_W + 7];
    return ok;
  endfunction

  fes_state_t    st;
  fes_family_t   fam_q;
  logic [XW:0]   idx_q, last_q;
  logic [2:0]    step_q;
  logic          fail_q, pass_q;
  logic [XW:0]   prot_q;

  logic [XW:0]   win_cnt;
  logic [XW-1:0] sec_lo;
  logic [AW-1:0] cur_sa;
  logic          cur_prot, past_end;
  logic          waiting, min_done, expired, rdy;
  logic          erase_ok_evt, timeout_evt;
  fes_op_t       op;
  logic [AW-1:0] gen_addr;
  logic [DW-1:0] gen_data;
  logic          gen_last;

  fes_prot_count #(.NSECT(NSECT)) u_cnt (
    .protect_map (protect_map),
    .first       (first_idx[XW-1:0]),
    .last        (last_idx[XW-1:0]),
    .count       (win_cnt)
  );

  assign sec_lo   = idx_q[XW-1:0];
  assign cur_sa   = sect_addr_flat[sec_lo*AW +: AW];
  assign cur_prot = protect_map[sec_lo];
  assign past_end = idx_q > last_q;
  assign waiting  = (st == ST_WAIT) || (st == ST_PRD) || (st == ST_PCHK);
  assign rdy      = lanes_ready(fl_rdata);
  assign erase_ok_evt = (st == ST_PCHK) && rdy;
  assign timeout_evt  = (st == ST_PCHK) && !rdy && expired;

  fes_wait_timer #(
    .MIN_WAIT_CYC (MIN_WAIT_CYC),
    .TIMEOUT_CYC  (TIMEOUT_CYC),
    .TICK_CYC     (TICK_CYC)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (st == ST_CMD),
    .run      (waiting),
    .min_done (min_done),
    .expired  (expired),
    .tick     (tick)
  );

  always_comb begin
    unique case (st)
      ST_SUSP: op = OP_SUSPEND;
      ST_RDM:  op = OP_READMODE;
      default: op = OP_ERASE;
    endcase
  end

  fes_cmd_gen #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_gen (
    .fam       (fam_q),
    .op        (op),
    .step      (step_q),
    .base      (bank_base),
    .saddr     (cur_sa),
    .addr      (gen_addr),
    .data      (gen_data),
    .last_step (gen_last)
  );

  assign fl_we    = (st == ST_CMD) || (st == ST_SUSP) || (st == ST_RDM);
  assign fl_re    = (st == ST_PRD);
  assign fl_addr  = (st == ST_PRD) ? cur_sa : gen_addr;
  assign fl_wdata = gen_data;
  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_FIN);
  assign pass     = pass_q;
  assign prot_cnt = prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      fam_q  <= FAM_STATUS;
      idx_q  <= '0;
      last_q <= '0;
      step_q <= '0;
      fail_q <= 1'b0;
      pass_q <= 1'b0;
      prot_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          fam_q <= fes_family_t'(family);
          if (range_bad(first_idx, last_idx)) begin
            prot_q <= '0;
            pass_q <= 1'b0;
            st     <= ST_FIN;
          end else begin
            idx_q  <= {1'b0, first_idx[XW-1:0]};
            last_q <= {1'b0, last_idx[XW-1:0]};
            prot_q <= win_cnt;
            fail_q <= 1'b0;
            st     <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (past_end) begin
            pass_q <= 1'b1;
            st     <= ST_FIN;
          end else if (cur_prot) begin
            idx_q <= idx_q + 1'b1;
          end else begin
            step_q <= '0;
            st     <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (gen_last) st <= ST_WAIT;
          else step_q <= step_q + 1'b1;
        end
        ST_WAIT: if (min_done) st <= ST_PRD;
        ST_PRD:  st <= ST_PCHK;
        ST_PCHK: begin
          if (erase_ok_evt) st <= ST_RDM;
          else if (timeout_evt) begin
            fail_q <= 1'b1;
            st     <= (fam_q == FAM_STATUS) ? ST_SUSP : ST_RDM;
          end else st <= ST_PRD;
        end
        ST_SUSP: st <= ST_RDM;
        ST_RDM: begin
          if (fail_q) begin
            pass_q <= 1'b0;
            st     <= ST_FIN;
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= ST_SEL;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fes_erase_chk.sv
module fes_erase_chk #(
  parameter int LANES = 2,
  parameter int LANE_W = 16,
  localparam int DW = LANES * LANE_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          busy,
  input logic          tick,
  input logic          waiting,
  input logic          fl_we,
  input logic          fl_re,
  input logic [DW-1:0] fl_wdata,
  input logic          fam_q,
  input logic          erase_ok_evt
);
  function automatic logic [DW-1:0] bc(input logic [7:0] b);
    logic [DW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*LANE_W +: LANE_W] = LANE_W'(b);
    return r;
  endfunction

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_tick_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> waiting);

  a_r1_bus_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(fl_we || fl_re));

  a_r3_status_order: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && !fam_q && fl_wdata == bc(8'h50)) |=> (fl_we && fl_wdata == bc(8'h20)));

  a_r7_suspend_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == bc(8'hB0)) |=> (fl_we && fl_wdata == bc(8'hFF)));

  a_r8_read_mode_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
    erase_ok_evt |=> (fl_we && fl_wdata == (fam_q ? bc(8'hF0) : bc(8'hFF))));
endmodule

bind fes_erase_seq fes_erase_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .done         (done),
  .busy         (busy),
  .tick         (tick),
  .waiting      (waiting),
  .fl_we        (fl_we),
  .fl_re        (fl_re),
  .fl_wdata     (fl_wdata),
  .fam_q        (fam_q),
  .erase_ok_evt (erase_ok_evt)
);

// File: tb/sim_fes_erase_seq.sv
`timescale 1ns/1ps
module sim_fes_erase_seq;
  localparam int NSECT = 8, AW = 20, LANES = 2, LANE_W = 16, DW = 32;
  localparam int MINW = 20, TMO = 120, TICKC = 16, IW = 5, XW = 3;

  logic clk = 0, rst_n = 0, start = 0, family = 0;
  logic signed [IW-1:0] first_idx = 0, last_idx = 0;
  logic [NSECT-1:0] protect_map = 0;
  logic [NSECT*AW-1:0] sect_addr_flat;
  logic [AW-1:0] bank_base = 20'h10000;
  logic fl_we, fl_re, busy, tick, done, pass;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata = 0;
  logic [XW:0] prot_cnt;

  always #2 clk = ~clk;

  fes_erase_seq #(.NSECT(NSECT), .AW(AW), .LANES(LANES), .LANE_W(LANE_W),
    .MIN_WAIT_CYC(MINW), .TIMEOUT_CYC(TMO), .TICK_CYC(TICKC)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  int cyc = 0, wr_n = 0, exp_n = 0, rd_since = 0, reads_tgt = 0, ticks = 0;
  int last_go = 0, go_pend = 0, gap_bad = 0, gaps = 0;
  logic [AW-1:0] log_a [0:63], exp_a [0:63];
  logic [DW-1:0] log_d [0:63], exp_d [0:63];
  logic [AW-1:0] stuck_addr = '1, half_addr = '1;
  int m_ready = 3;

  function automatic logic [DW-1:0] cmd(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction
  function automatic logic [AW-1:0] sa(input int i);
    return 20'h10000 + AW'(i) * 20'h01000;
  endfunction

  // Flash model and bus monitor, on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (tick) ticks++;
    if (fl_we) begin
      if (wr_n < 64) begin log_a[wr_n] = fl_addr; log_d[wr_n] = fl_wdata; end
      wr_n++;
      rd_since = 0;
      if (fl_wdata == cmd(8'hD0) || fl_wdata == cmd(8'h30)) begin
        last_go = cyc; go_pend = 1;
      end
    end
    if (fl_re) begin
      if (go_pend) begin
        gaps++;
        if (cyc - last_go != MINW + 1) gap_bad++;
        go_pend = 0;
      end
      if (fl_addr == stuck_addr || fl_addr == half_addr) reads_tgt++;
      rd_since++;
      if (fl_addr == stuck_addr) fl_rdata = 32'h0;
      else if (fl_addr == half_addr) fl_rdata = 32'h0000_0080;
      else if (rd_since >= m_ready) fl_rdata = 32'h0080_0080;
      else fl_rdata = 32'h0;
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    wr_n = 0; exp_n = 0; reads_tgt = 0; ticks = 0; gap_bad = 0; gaps = 0; go_pend = 0;
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [7:0] b);
    exp_a[exp_n] = a; exp_d[exp_n] = cmd(b); exp_n++;
  endtask

  task automatic push_status(input int s);
    push(sa(s), 8'h50); push(sa(s), 8'h20); push(sa(s), 8'hD0);
  endtask

  task automatic push_unlock(input int s);
    push(bank_base + 20'h555, 8'hAA); push(bank_base + 20'h2AA, 8'h55);
    push(bank_base + 20'h555, 8'h80); push(bank_base + 20'h555, 8'hAA);
    push(bank_base + 20'h2AA, 8'h55); push(sa(s), 8'h30);
  endtask

  task automatic compare_log(input string tag);
    check(wr_n == exp_n, {tag, " write count"}, wr_n, exp_n);
    for (int i = 0; i < exp_n && i < wr_n; i++) begin
      check(log_a[i] == exp_a[i], {tag, " write addr"}, log_a[i], exp_a[i]);
      check(log_d[i] == exp_d[i], {tag, " write data"}, log_d[i], exp_d[i]);
    end
  endtask

  task automatic pulse_start(input logic fam, input int f, input int l);
    @(negedge clk);
    family = fam; first_idx = IW'(f); last_idx = IW'(l); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // Returns falling edges from the start pulse to the done pulse (0 if none).
  task automatic wait_done(output int n);
    n = 0;
    for (int i = 1; i < 20000; i++) begin
      if (done) begin n = i; break; end
      @(negedge clk);
    end
  endtask

  function automatic int ok_ticks(input int reads);
    return (MINW + 2 * reads) / TICKC;
  endfunction
  function automatic int tmo_wait_cycles();
    int c;
    c = MINW + 1;
    while (c < TMO) c += 2;
    return c + 1;
  endfunction

  task automatic t_reset();
    check(!busy && !done && !fl_we && !fl_re && !tick && !pass && prot_cnt == 0,
          "reset state", {busy, done, fl_we, tick}, 0);
  endtask

  task automatic t_bad_range();
    int n;
    clear_logs();
    pulse_start(0, 3, 2);
    check(done && !pass, "R1 first>last done next cycle", {done, pass}, 2'b10);
    check(prot_cnt == 0, "R1 count zero", prot_cnt, 0);
    repeat (3) @(negedge clk);
    pulse_start(1, -1, 2);
    check(done && !pass, "R1 negative first", {done, pass}, 2'b10);
    repeat (3) @(negedge clk);
    pulse_start(0, 2, 8);
    wait_done(n);
    check(n == 1 && !pass, "R1 last past table", n, 1);
    check(wr_n == 0 && reads_tgt == 0, "R1 no bus cycles", wr_n, 0);
  endtask

  task automatic t_status_ok();
    int n;
    clear_logs(); protect_map = 8'b0000_0100; m_ready = 3;
    push_status(1); push(bank_base, 8'hFF); push_status(3); push(bank_base, 8'hFF);
    pulse_start(0, 1, 3);
    repeat (4) @(negedge clk);
    pulse_start(1, 0, 7);   // R10: ignored while busy
    wait_done(n);
    check(n > 0, "R10 done seen", n, 1);
    check(pass == 1, "R10 pass after good run", pass, 1);
    check(prot_cnt == 1, "R2 protected count", prot_cnt, 1);
    compare_log("R3 R2 status sequence");
    check(gaps == 2 && gap_bad == 0, "R5 min wait gap", gap_bad, 0);
    check(ticks == 2 * ok_ticks(3), "R9 tick count", ticks, 2 * ok_ticks(3));
    @(negedge clk);
    check(!done, "R10 done is one cycle", done, 0);
  endtask

  task automatic t_unlock_ok();
    int n;
    clear_logs(); protect_map = 8'b0000_0100; m_ready = 1;
    push_unlock(0); push(bank_base, 8'hF0); push_unlock(1); push(bank_base, 8'hF0);
    pulse_start(1, 0, 2);
    wait_done(n);
    check(pass == 1 && prot_cnt == 1, "R4 unlock pass", {pass, prot_cnt}, 5'b10001);
    compare_log("R4 R8 unlock sequence");
    check(gap_bad == 0, "R5 unlock gap", gap_bad, 0);
  endtask

  task automatic t_status_timeout();
    int n, w;
    clear_logs(); protect_map = 0; m_ready = 2; stuck_addr = sa(5);
    push_status(4); push(bank_base, 8'hFF);
    push_status(5); push(sa(5), 8'hB0); push(bank_base, 8'hFF);
    pulse_start(0, 4, 6);
    wait_done(n);
    w = tmo_wait_cycles();
    check(pass == 0, "R7 fail flag", pass, 0);
    compare_log("R7 suspend and stop");
    check(reads_tgt == (w - MINW) / 2, "R7 poll reads to timeout", reads_tgt, (w - MINW) / 2);
    check(ticks == ok_ticks(2) + w / TICKC, "R9 ticks with timeout", ticks, ok_ticks(2) + w / TICKC);
    stuck_addr = '1;
  endtask

  task automatic t_partial_lanes();
    int n, w;
    clear_logs(); protect_map = 0; half_addr = sa(2);
    push_unlock(2); push(bank_base, 8'hF0);
    pulse_start(1, 2, 2);
    wait_done(n);
    w = tmo_wait_cycles();
    check(pass == 0, "R6 partial lanes not done", pass, 0);
    check(reads_tgt == (w - MINW) / 2, "R6 kept polling", reads_tgt, (w - MINW) / 2);
    compare_log("R7 unlock timeout without suspend");
    half_addr = '1;
  endtask

  task automatic t_all_protected();
    int n;
    clear_logs(); protect_map = 8'b0000_0111;
    pulse_start(0, 0, 2);
    wait_done(n);
    check(n == 5, "R2 all protected timing", n, 5);
    check(pass && prot_cnt == 3, "R2 all protected result", prot_cnt, 3);
    check(wr_n == 0 && !tick, "R2 protected untouched", wr_n, 0);
  endtask

  bit finished = 0;
  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSECT; i++) sect_addr_flat[i*AW +: AW] = sa(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bad_range();
    t_status_ok();
    t_unlock_ok();
    t_status_timeout();
    t_partial_lanes();
    t_all_protected();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule